// File: doc/BRIEF.md
# Integer Add, Subtract and Set-Less-Than Unit

This block is the integer arithmetic slice of a 32-bit load/store processor datapath. It is purely combinational. From a 3-bit operation code it produces one of six results:

- add, with or without an overflow trap;
- subtract, with or without an overflow trap;
- signed set-less-than;
- unsigned set-less-than.

The second operand is either a register value or a 16-bit immediate. The immediate is widened by copying its top bit into every upper bit.

One carry-chain adder serves every operation. Subtraction and comparison feed it the bitwise complement of the second operand and a carry-in of one. The unit also reports the adder carry-out and an overflow trap request. Only the trapping add and subtract raise that request. The surrounding pipeline decides what to do with it. The result always holds the low 32 bits of the sum, whether or not overflow occurred.

Top module: `int_asc_unit`

## Requirements
- R1: Operation code 0 (trapping add) and code 1 (plain add) give result = low 32 bits of A + B. carry_o is the carry out of bit 31.
- R2: Code 2 (trapping subtract) and code 3 (plain subtract) give result = low 32 bits of A - B. carry_o is the carry of A + ~B + 1, which is 1 exactly when A >= B taken as unsigned.
- R3: For code 0, ovf_trap_o is 1 exactly when A and B have the same sign and the sum's sign differs from them.
- R4: For code 2, ovf_trap_o is 1 exactly when A and B have different signs and the difference's sign differs from A's.
- R5: Codes 1 and 3 never raise ovf_trap_o. Their result and carry match those of codes 0 and 2.
- R6: When use_imm_i is 1, B is imm_i sign-extended to 32 bits, for every operation code including the plain add.
- R7: Code 4 (signed compare) returns 32'd1 when A < B as two's-complement numbers and 32'd0 otherwise. For example, -4 against 10 gives 1.
- R8: Code 5 (unsigned compare) returns 32'd1 when A < B as unsigned numbers and 32'd0 otherwise. For example, 0xFFFFFFFC against 10 gives 0.
- R9: Codes 4 and 5 never raise ovf_trap_o. Their carry_o equals the subtract carry of R2.
- R10: Codes 6 and 7 give a result of 0, carry_o of 0 and ovf_trap_o of 0.
- R11: When use_imm_i is 0, B is rt_i and imm_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 3 | Operation code: 0 add-trap, 1 add, 2 sub-trap, 3 sub, 4 signed compare, 5 unsigned compare |
| rs_i | input | 32 | First operand A |
| rt_i | input | 32 | Register second operand |
| imm_i | input | 16 | Immediate second operand, sign-extended before use |
| use_imm_i | input | 1 | Selects the immediate as B when 1 |
| result_o | output | 32 | Low 32 bits of the operation result |
| carry_o | output | 1 | Carry out of bit 31 of the shared adder |
| ovf_trap_o | output | 1 | Signed overflow trap request |

## Verification
The unit holds no state, so any error in the inverted operand, the carry-in or the overflow term shows up at the ports in the same evaluation as the inputs that expose it. It shows up as a wrong result, a wrong carry, or a trap raised where none is due or missing where one is due. A wrong carry-in appears as an off-by-one difference. A wrong overflow term appears only at the sign boundaries: 0x7FFFFFFF+1, 0x80000000-1 and mixed-sign compares. Those operands are therefore driven on purpose, in addition to many random operand pairs. Every vector is compared against an arithmetic model computed with 64-bit integers.

// File: rtl/asc_pkg.sv
package asc_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    ASC_ADD  = 3'd0,
    ASC_ADDU = 3'd1,
    ASC_SUB  = 3'd2,
    ASC_SUBU = 3'd3,
    ASC_SLT  = 3'd4,
    ASC_SLTU = 3'd5
  } asc_op_e;
endpackage

// File: rtl/asc_opnd_sel.sv
module asc_opnd_sel #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [W-1:0]     rt_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  logic             negate_i,
  output logic [W-1:0]     b_add_o,
  output logic             cin_o
);
  localparam int EXT_W = W - IMM_W;

  logic [W-1:0] imm_ext;
  logic [W-1:0] b_sel;

  // R6: replicate the immediate's top bit into the upper part
  assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};

  always_comb begin
    b_sel   = use_imm_i ? imm_ext : rt_i;
    b_add_o = negate_i ? ~b_sel : b_sel;
    cin_o   = negate_i;
  end
endmodule

// File: rtl/asc_adder.sv
module asc_adder #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0] chain;

  assign chain[0] = cin_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p;
    assign p          = a_i[i] ^ b_i[i];
    assign sum_o[i]   = p ^ chain[i];
    assign chain[i+1] = (a_i[i] & b_i[i]) | (p & chain[i]);
  end

  assign cout_o = chain[W];
endmodule

// File: rtl/asc_flags.sv
module asc_flags (
  input  logic a_msb_i,
  input  logic b_msb_i,
  input  logic s_msb_i,
  input  logic cout_i,
  output logic sovf_o,
  output logic lt_s_o,
  output logic lt_u_o
);
  // b_msb_i is the top bit of the operand actually fed to the adder
  // (already inverted for subtraction), so one rule covers both R3 and R4.
  always_comb begin
    sovf_o = (a_msb_i == b_msb_i) && (s_msb_i != a_msb_i);
    lt_s_o = s_msb_i ^ sovf_o;
    lt_u_o = ~cout_i;
  end
endmodule

// File: rtl/int_asc_unit.sv
module int_asc_unit #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input  logic [2:0]       op_i,
  input  logic [W-1:0]     rs_i,
  input  logic [W-1:0]     rt_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  output logic [W-1:0]     result_o,
  output logic             carry_o,
  output logic             ovf_trap_o
);
  import asc_pkg::*;

  asc_op_e      op;
  logic         op_known;
  logic         negate;
  logic         traps;
  logic [W-1:0] b_add;
  logic         cin;
  logic [W-1:0] sum;
  logic         cout;
  logic         sovf;
  logic         lt_s;
  logic         lt_u;

  always_comb begin
    op       = asc_op_e'(op_i);
    op_known = 1'b1;
    negate   = 1'b0;
    traps    = 1'b0;
    case (op)
      ASC_ADD:  traps = 1'b1;
      ASC_ADDU: ;
      ASC_SUB:  begin negate = 1'b1; traps = 1'b1; end
      ASC_SUBU: negate = 1'b1;
      ASC_SLT,
      ASC_SLTU: negate = 1'b1;
      default:  op_known = 1'b0;
    endcase
  end

  asc_opnd_sel #(.W(W), .IMM_W(IMM_W)) u_opnd (
    .rt_i      (rt_i),
    .imm_i     (imm_i),
    .use_imm_i (use_imm_i),
    .negate_i  (negate),
    .b_add_o   (b_add),
    .cin_o     (cin)
  );

  asc_adder #(.W(W)) u_add (
    .a_i    (rs_i),
    .b_i    (b_add),
    .cin_i  (cin),
    .sum_o  (sum),
    .cout_o (cout)
  );

  asc_flags u_flags (
    .a_msb_i (rs_i[W-1]),
    .b_msb_i (b_add[W-1]),
    .s_msb_i (sum[W-1]),
    .cout_i  (cout),
    .sovf_o  (sovf),
    .lt_s_o  (lt_s),
    .lt_u_o  (lt_u)
  );

  always_comb begin
    case (op)
      ASC_SLT:  result_o = {{(W-1){1'b0}}, lt_s};
      ASC_SLTU: result_o = {{(W-1){1'b0}}, lt_u};
      default:  result_o = op_known ? sum : '0;
    endcase
    carry_o    = op_known & cout;
    ovf_trap_o = traps & sovf;
  end
endmodule

// File: rtl/asc_checker.sv
module asc_checker #(
  parameter int W     = 32,
  parameter int IMM_W = 16
) (
  input logic [2:0]       op_i,
  input logic [W-1:0]     rs_i,
  input logic [W-1:0]     rt_i,
  input logic [IMM_W-1:0] imm_i,
  input logic             use_imm_i,
  input logic [W-1:0]     result_o,
  input logic             carry_o,
  input logic             ovf_trap_o
);
  logic [W-1:0] b_val;
  logic         b_neg;

  always_comb begin
    b_val = use_imm_i ? {{(W-IMM_W){imm_i[IMM_W-1]}}, imm_i} : rt_i;
    b_neg = b_val[W-1];

    if (op_i == 3'd4 || op_i == 3'd5)
      AST_CMP_IS_BOOL: assert (result_o[W-1:1] == '0); // R7

    if (op_i != 3'd0 && op_i != 3'd2)
      AST_NO_TRAP_PLAIN: assert (!ovf_trap_o); // R5

    if (op_i > 3'd5)
      AST_UNUSED_ZERO: assert (result_o == '0 && !carry_o && !ovf_trap_o); // R10

    if (op_i == 3'd0 && ovf_trap_o)
      AST_ADD_OVF_SIGNS: assert (rs_i[W-1] == b_neg && result_o[W-1] != b_neg); // R3

    if (op_i == 3'd2 && ovf_trap_o)
      AST_SUB_OVF_SIGNS: assert (rs_i[W-1] != b_neg && result_o[W-1] != rs_i[W-1]); // R4

    if (op_i == 3'd5)
      AST_UNSIGNED_LT: assert (result_o[0] == (rs_i < b_val)); // R8
  end
endmodule

bind int_asc_unit asc_checker #(.W(W), .IMM_W(IMM_W)) u_chk (
  .op_i       (op_i),
  .rs_i       (rs_i),
  .rt_i       (rt_i),
  .imm_i      (imm_i),
  .use_imm_i  (use_imm_i),
  .result_o   (result_o),
  .carry_o    (carry_o),
  .ovf_trap_o (ovf_trap_o)
);

// File: tb/int_asc_unit_tb.sv
module int_asc_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [2:0]  op;
  logic [31:0] rs;
  logic [31:0] rt;
  logic [15:0] imm;
  logic        use_imm;
  logic [31:0] result;
  logic        carry;
  logic        trap;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  int_asc_unit u_dut (
    .op_i       (op),
    .rs_i       (rs),
    .rt_i       (rt),
    .imm_i      (imm),
    .use_imm_i  (use_imm),
    .result_o   (result),
    .carry_o    (carry),
    .ovf_trap_o (trap)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic string tag_of(input logic [2:0] o, input logic ui);
    string t;
    case (o)
      3'd0: t = "R1/R3";
      3'd1: t = "R1/R5";
      3'd2: t = "R2/R4";
      3'd3: t = "R2/R5";
      3'd4: t = "R7/R9";
      3'd5: t = "R8/R9";
      default: t = "R10";
    endcase
    return ui ? {t, "/R6"} : {t, "/R11"};
  endfunction

  task automatic apply(input logic [2:0] o, input logic [31:0] a,
                       input logic [31:0] r, input logic [15:0] im,
                       input logic ui);
    logic [31:0] b;
    longint      sa, sb, wide;
    logic [32:0] s33;
    logic [31:0] e_res;
    logic        e_c, e_t;
    string       t;
    @(posedge clk);
    #1;
    op = o; rs = a; rt = r; imm = im; use_imm = ui;
    b  = ui ? {{16{im[15]}}, im} : r;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    e_res = '0; e_c = 1'b0; e_t = 1'b0;
    case (o)
      3'd0, 3'd1: begin
        s33   = {1'b0, a} + {1'b0, b};
        e_res = s33[31:0];
        e_c   = s33[32];
        wide  = sa + sb;
        e_t   = (o == 3'd0) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      3'd2, 3'd3: begin
        e_res = a - b;
        e_c   = (a >= b);
        wide  = sa - sb;
        e_t   = (o == 3'd2) && (wide > 64'sd2147483647 || wide < -64'sd2147483648);
      end
      3'd4: begin e_res = {31'd0, sa < sb}; e_c = (a >= b); end
      3'd5: begin e_res = {31'd0, a < b};   e_c = (a >= b); end
      default: ;
    endcase
    @(negedge clk);
    t = tag_of(o, ui);
    checks++;
    if (result !== e_res || carry !== e_c || trap !== e_t) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h: got res=%h c=%b t=%b, exp res=%h c=%b t=%b",
               t, o, a, b, result, carry, trap, e_res, e_c, e_t);
    end
  endtask

  initial begin
    rst_n = 1'b0;
    op = 3'd0; rs = '0; rt = '0; imm = '0; use_imm = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // quiescent inputs: zero result, no carry, no trap (R1)
    apply(3'd0, 32'h0, 32'h0, 16'h0, 1'b0);
    // R1: carry out of bit 31 with wrap to zero
    apply(3'd1, 32'hFFFFFFFF, 32'h1, 16'h0, 1'b0);
    // R3: positive + positive overflow; negative + negative overflow
    apply(3'd0, 32'h7FFFFFFF, 32'h1, 16'h0, 1'b0);
    apply(3'd0, 32'h80000000, 32'h80000000, 16'h0, 1'b0);
    // R3: mixed signs never overflow
    apply(3'd0, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 1'b0);
    // R5: plain add with the same overflowing operands
    apply(3'd1, 32'h7FFFFFFF, 32'h1, 16'h0, 1'b0);
    // R4: overflowing and non-overflowing subtracts
    apply(3'd2, 32'h80000000, 32'h1, 16'h0, 1'b0);
    apply(3'd2, 32'h7FFFFFFF, 32'hFFFFFFFF, 16'h0, 1'b0);
    apply(3'd2, 32'h5, 32'h5, 16'h0, 1'b0);
    // R2/R5: plain subtract with borrow
    apply(3'd3, 32'h80000000, 32'h1, 16'h0, 1'b0);
    apply(3'd3, 32'h0, 32'h1, 16'h0, 1'b0);
    // R7: -4 < 10 signed gives 1; R8: same patterns unsigned give 0
    apply(3'd4, 32'hFFFFFFFC, 32'd10, 16'h0, 1'b0);
    apply(3'd5, 32'hFFFFFFFC, 32'd10, 16'h0, 1'b0);
    // R9: compare across the overflow boundary does not trap
    apply(3'd4, 32'h80000000, 32'h7FFFFFFF, 16'h0, 1'b0);
    apply(3'd4, 32'h7FFFFFFF, 32'h80000000, 16'h0, 1'b0);
    // R6: negative immediate for trapping add and plain add
    apply(3'd0, 32'h10, 32'h0, 16'hFFFF, 1'b1);
    apply(3'd1, 32'h0, 32'h0, 16'h8000, 1'b1);
    apply(3'd4, 32'h0, 32'h0, 16'hFFFF, 1'b1);
    // R11: immediate ignored with register operand selected
    apply(3'd0, 32'h100, 32'h23, 16'h7FFF, 1'b0);
    // R10: unused codes
    apply(3'd6, 32'hFFFFFFFF, 32'hFFFFFFFF, 16'hFFFF, 1'b0);
    apply(3'd7, 32'h7FFFFFFF, 32'h1, 16'h1, 1'b1);
    // random sweep over every code, with sign-boundary bias
    for (int i = 0; i < 600; i++) begin
      logic [31:0] a, r;
      a = $urandom;
      r = $urandom;
      if (i % 7 == 0) a = {a[31], {31{~a[31]}}};
      if (i % 5 == 0) r = {r[31], 31'd0};
      apply(3'(i % 8), a, r, 16'($urandom), 1'((i / 8) % 2));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule